// File: doc/BRIEF.md
# Store-Indirect Control Sequencer for a 16-bit Accumulator Machine

This block is the hardwired control unit and a minimal register datapath for a small accumulator machine with 16-bit words and a 12-bit address space. It holds a program counter and a memory address register of 12 bits each, and a memory buffer, an instruction register and an accumulator of 16 bits each. All of them exchange values over one internal bus. The block fetches an instruction, decodes its 4-bit opcode, and executes the store-indirect operation. That operation writes the accumulator to the location whose address is held in a pointer word, and it does so as a fixed chain of single register transfers.

A one-hot timing counter paces every phase, and the counter is cleared whenever the phase changes. During execution, each timing step also raises a fixed group of five numbered control lines (P0 to P4). These lines are visible on a debug port next to the register contents and the bus value. Any opcode other than store-indirect stops the machine until the next reset. Memory is outside the block and is reached through an address, a write-data and write-enable pair, and a read-data input that is valid within the same step.

Top module: `accseq_core`

## Requirements
- R1: A synchronous reset clears PC, MAR, MBR, IR and AC to zero, sets the timing counter to its first step (dbg_step = 6'b000001) and the phase to fetch (dbg_phase = 0), and holds mem_we low.
- R2: The timing counter is always one-hot. It advances one bit per cycle within a phase and returns to bit 0 whenever the phase changes.
- R3: Fetch takes two steps. Step 0 copies PC into MAR. Step 1 loads IR from memory at MAR and adds one to PC, wrapping modulo 4096.
- R4: Decode (dbg_phase = 1) takes one step and inspects IR[15:12]. The value 4'hE enters execution (dbg_phase = 2). Any other value enters a halt (dbg_phase = 3, halted = 1) that lasts until reset, with PC frozen and no memory write.
- R5: Execution performs these transfers in order, one per step from T0 to T4: MAR gets IR[11:0]; MBR gets memory at MAR; MAR gets MBR; MBR gets AC; memory at MAR gets MBR. Only the pointed-to word changes; the pointer word and all other words are unchanged.
- R6: When MAR is loaded from MBR, it keeps only MBR[11:0], so the upper four bits of the pointer word are ignored.
- R7: dbg_ctl bit k is control line Pk. During execution: T0 = 5'b01111, T1 = 5'b11000, T2 = 5'b01011, T3 = 5'b11100, T4 = 5'b00011, T5 = 0. Outside execution dbg_ctl is 0.
- R8: mem_we is high only on execution step T4, with mem_addr = MAR and mem_wdata = MBR.
- R9: At most one source drives the bus in a cycle. dbg_bus shows that source's value: PC zero-extended, the full IR word, MBR, AC (zero since reset), or read data.
- R10: Execution step T5 clears the timing counter and returns to fetch, so one store-indirect instruction takes 9 cycles from fetch to the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory address (MAR) |
| mem_rdata | input | 16 | Memory read data for mem_addr, valid in the same step |
| mem_wdata | output | 16 | Memory write data (bus value, equal to MBR when writing) |
| mem_we | output | 1 | Memory write enable |
| dbg_bus | output | 16 | Current internal bus value |
| dbg_pc | output | 12 | Program counter |
| dbg_mar | output | 12 | Memory address register |
| dbg_mbr | output | 16 | Memory buffer register |
| dbg_ir | output | 16 | Instruction register |
| dbg_ac | output | 16 | Accumulator |
| dbg_step | output | 6 | One-hot timing step |
| dbg_phase | output | 2 | 0 fetch, 1 decode, 2 execute, 3 halt |
| dbg_ctl | output | 5 | Control lines P0..P4 (bit k = Pk) |
| halted | output | 1 | High while halted |

## Verification
The assertions check several properties on every cycle. They check that the bus has a single driver and that the timing counter stays one-hot and shifts by one during execution. They check that the PC increment happens at the end of fetch, that the pointer is cut to 12 bits at T2, and that the write is confined to T4 and carries MBR. They also check that T5 returns to fetch and that a halt is sticky. Only the bench's scenarios can show the end result in memory. That covers the right word being overwritten through the pointer while the pointer itself and every other location stay intact, across a sweep of pointers with varied high bits and an address at the top of memory. The bench scenarios also show the exact per-step control-line groups and bus values, the halt on an unsupported opcode, and recovery from a reset asserted in the middle of execution.

// File: rtl/accseq_pkg.sv
package accseq_pkg;

  // Length of the execute sequence (five transfers plus the clearing step)
  localparam int NSTEP = 6;
  // Number of control lines raised during execution
  localparam int NCTL  = 5;
  // Bus sources and their positions in the source-enable vector
  localparam int NSRC  = 5;
  localparam int S_PC  = 0;
  localparam int S_IR  = 1;
  localparam int S_MBR = 2;
  localparam int S_AC  = 3;
  localparam int S_MEM = 4;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_DECODE = 2'd1,
    PH_EXEC   = 2'd2,
    PH_HALT   = 2'd3
  } phase_e;

  typedef struct packed {
    logic ld_mar;
    logic ld_mbr;
    logic ld_ir;
    logic inc_pc;
    logic mem_we;
  } load_t;

  // Control-line group for an execute step; bit k is line Pk
  function automatic logic [NCTL-1:0] ctl_for_step(input logic [NSTEP-1:0] oh);
    logic [NCTL-1:0] r;
    r = '0;
    if (oh[0]) r = 5'b01111;
    if (oh[1]) r = 5'b11000;
    if (oh[2]) r = 5'b01011;
    if (oh[3]) r = 5'b11100;
    if (oh[4]) r = 5'b00011;
    return r;
  endfunction

endpackage

// File: rtl/accseq_timer.sv
module accseq_timer
  import accseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [NSTEP-1:0] step
);

  localparam logic [NSTEP-1:0] FIRST = NSTEP'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      step <= FIRST;
    end else begin
      step <= {step[NSTEP-2:0], step[NSTEP-1]};
    end
  end

endmodule

// File: rtl/accseq_ctrl.sv
module accseq_ctrl
  import accseq_pkg::*;
#(
  parameter int             OPW       = 4,
  parameter logic [OPW-1:0] STOREI_OP = 'hE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSTEP-1:0] step,
  input  logic [OPW-1:0]   opcode,
  output phase_e           phase,
  output logic [NSRC-1:0]  src_en,
  output load_t            ld,
  output logic             clr,
  output logic [NCTL-1:0]  ctl
);

  phase_e nxt;

  always_comb begin
    nxt    = phase;
    src_en = '0;
    ld     = '0;
    clr    = 1'b0;
    ctl    = '0;
    unique case (phase)
      PH_FETCH: begin
        if (step[0]) begin
          src_en[S_PC] = 1'b1;
          ld.ld_mar    = 1'b1;
        end
        if (step[1]) begin
          src_en[S_MEM] = 1'b1;
          ld.ld_ir      = 1'b1;
          ld.inc_pc     = 1'b1;
          nxt           = PH_DECODE;
          clr           = 1'b1;
        end
      end
      PH_DECODE: begin
        nxt = (opcode == STOREI_OP) ? PH_EXEC : PH_HALT;
        clr = 1'b1;
      end
      PH_EXEC: begin
        ctl = ctl_for_step(step);
        if (step[0]) begin
          src_en[S_IR] = 1'b1;
          ld.ld_mar    = 1'b1;
        end
        if (step[1]) begin
          src_en[S_MEM] = 1'b1;
          ld.ld_mbr     = 1'b1;
        end
        if (step[2]) begin
          src_en[S_MBR] = 1'b1;
          ld.ld_mar     = 1'b1;
        end
        if (step[3]) begin
          src_en[S_AC] = 1'b1;
          ld.ld_mbr    = 1'b1;
        end
        if (step[4]) begin
          src_en[S_MBR] = 1'b1;
          ld.mem_we     = 1'b1;
        end
        if (step[5]) begin
          nxt = PH_FETCH;
          clr = 1'b1;
        end
      end
      PH_HALT: begin
        clr = 1'b1;
      end
      default: begin
        nxt = PH_HALT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_FETCH;
    end else begin
      phase <= nxt;
    end
  end

endmodule

// File: rtl/accseq_dpath.sv
module accseq_dpath
  import accseq_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_en,
  input  load_t           ld,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW-1:0]   bus,
  output logic [AW-1:0]   pc,
  output logic [AW-1:0]   mar,
  output logic [DW-1:0]   mbr,
  output logic [DW-1:0]   ir,
  output logic [DW-1:0]   ac
);

  function automatic logic [AW-1:0] addr_part(input logic [DW-1:0] w);
    return w[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] pc_after(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  function automatic logic [DW-1:0] widen(input logic [AW-1:0] a);
    return DW'(a);
  endfunction

  logic [DW-1:0] src_val [NSRC];

  assign src_val[S_PC]  = widen(pc);
  assign src_val[S_IR]  = ir;
  assign src_val[S_MBR] = mbr;
  assign src_val[S_AC]  = ac;
  assign src_val[S_MEM] = mem_rdata;

  // Gated OR of all sources; the controller enables at most one
  always_comb begin
    bus = '0;
    for (int s = 0; s < NSRC; s++) begin
      bus = bus | (src_val[s] & {DW{src_en[s]}});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      ac  <= '0;
    end else begin
      if (ld.ld_mar) mar <= addr_part(bus);
      if (ld.ld_mbr) mbr <= bus;
      if (ld.ld_ir)  ir  <= bus;
      if (ld.inc_pc) pc  <= pc_after(pc);
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = bus;

endmodule

// File: rtl/accseq_core.sv
module accseq_core
  import accseq_pkg::*;
#(
  parameter int             DW        = 16,
  parameter int             AW        = 12,
  parameter int             OPW       = 4,
  parameter logic [OPW-1:0] STOREI_OP = 'hE
) (
  input  logic             clk,
  input  logic             rst,
  output logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DW-1:0]    mem_wdata,
  output logic             mem_we,
  output logic [DW-1:0]    dbg_bus,
  output logic [AW-1:0]    dbg_pc,
  output logic [AW-1:0]    dbg_mar,
  output logic [DW-1:0]    dbg_mbr,
  output logic [DW-1:0]    dbg_ir,
  output logic [DW-1:0]    dbg_ac,
  output logic [NSTEP-1:0] dbg_step,
  output logic [1:0]       dbg_phase,
  output logic [NCTL-1:0]  dbg_ctl,
  output logic             halted
);

  localparam int OP_LSB = DW - OPW;

  logic [NSTEP-1:0] step_w;
  logic             clr_w;
  phase_e           phase_w;
  logic [NSRC-1:0]  src_en_w;
  load_t            ld_w;
  logic [NCTL-1:0]  ctl_w;
  logic [DW-1:0]    ir_w;

  accseq_timer u_timer (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr_w),
    .step (step_w)
  );

  accseq_ctrl #(
    .OPW       (OPW),
    .STOREI_OP (STOREI_OP)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .step   (step_w),
    .opcode (ir_w[OP_LSB +: OPW]),
    .phase  (phase_w),
    .src_en (src_en_w),
    .ld     (ld_w),
    .clr    (clr_w),
    .ctl    (ctl_w)
  );

  accseq_dpath #(
    .DW (DW),
    .AW (AW)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .src_en    (src_en_w),
    .ld        (ld_w),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .bus       (dbg_bus),
    .pc        (dbg_pc),
    .mar       (dbg_mar),
    .mbr       (dbg_mbr),
    .ir        (ir_w),
    .ac        (dbg_ac)
  );

  assign mem_we    = ld_w.mem_we;
  assign dbg_ir    = ir_w;
  assign dbg_step  = step_w;
  assign dbg_phase = phase_w;
  assign dbg_ctl   = ctl_w;
  assign halted    = (phase_w == PH_HALT);

endmodule

// File: rtl/accseq_core_chk.sv
module accseq_core_chk
  import accseq_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       phase,
  input logic [NSTEP-1:0] step,
  input logic [NSRC-1:0]  src_en,
  input logic             mem_we,
  input logic [DW-1:0]    mem_wdata,
  input logic [AW-1:0]    pc,
  input logic [AW-1:0]    mar,
  input logic [DW-1:0]    mbr,
  input logic             halted
);

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst) $onehot0(src_en)); // R9
  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot(step)); // R2
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst) (phase == 2'd2 && !step[NSTEP-1]) |=> (step == ($past(step) << 1))); // R2
  AST_PC_INCREMENT: assert property (@(posedge clk) disable iff (rst) (phase == 2'd0 && step[1]) |=> (pc == AW'($past(pc) + AW'(1)))); // R3
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) halted |=> (halted && $stable(pc) && !mem_we)); // R4
  AST_MAR_LOW_BITS: assert property (@(posedge clk) disable iff (rst) (phase == 2'd2 && step[2]) |=> (mar == $past(mbr[AW-1:0]))); // R6
  AST_WRITE_STEP: assert property (@(posedge clk) disable iff (rst) mem_we |-> (phase == 2'd2 && step[4])); // R8
  AST_WRITE_DATA: assert property (@(posedge clk) disable iff (rst) mem_we |-> (mem_wdata == mbr)); // R8
  AST_T5_RETURN: assert property (@(posedge clk) disable iff (rst) (phase == 2'd2 && step[NSTEP-1]) |=> (phase == 2'd0 && step[0])); // R10

endmodule

bind accseq_core accseq_core_chk #(
  .DW (DW),
  .AW (AW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .phase     (dbg_phase),
  .step      (dbg_step),
  .src_en    (src_en_w),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .pc        (dbg_pc),
  .mar       (dbg_mar),
  .mbr       (dbg_mbr),
  .halted    (halted)
);

// File: tb/accseq_core_bench.sv
`timescale 1ns/1ps
module accseq_core_bench;

  localparam int DW    = 16;
  localparam int AW    = 12;
  localparam int DEPTH = 1 << AW;
  localparam int NI    = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] dbg_bus;
  logic [AW-1:0] dbg_pc;
  logic [AW-1:0] dbg_mar;
  logic [DW-1:0] dbg_mbr;
  logic [DW-1:0] dbg_ir;
  logic [DW-1:0] dbg_ac;
  logic [5:0]    dbg_step;
  logic [1:0]    dbg_phase;
  logic [4:0]    dbg_ctl;
  logic          halted;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  accseq_core u_accseq_core (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .dbg_bus   (dbg_bus),
    .dbg_pc    (dbg_pc),
    .dbg_mar   (dbg_mar),
    .dbg_mbr   (dbg_mbr),
    .dbg_ir    (dbg_ir),
    .dbg_ac    (dbg_ac),
    .dbg_step  (dbg_step),
    .dbg_phase (dbg_phase),
    .dbg_ctl   (dbg_ctl),
    .halted    (halted)
  );

  logic [DW-1:0] mem [DEPTH];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  function automatic logic [DW-1:0] fill_word(input int a);
    return 16'h8000 | DW'(a);
  endfunction
  function automatic logic [AW-1:0] x_of(input int i);
    return AW'(12'h100 + i * 7);
  endfunction
  function automatic logic [AW-1:0] tgt_of(input int i);
    return (i == NI - 1) ? 12'hFFF : AW'(12'h800 + i * 13);
  endfunction
  function automatic logic [DW-1:0] ptr_of(input int i);
    return {4'(15 - i), tgt_of(i)};
  endfunction
  function automatic logic [DW-1:0] instr_of(input int i);
    return {4'hE, x_of(i)};
  endfunction
  function automatic logic [DW-1:0] expect_word(input int a);
    logic [DW-1:0] e;
    e = fill_word(a);
    if (a < NI) e = instr_of(a);
    if (a == NI) e = 16'h7000;
    for (int i = 0; i < NI; i++) begin
      if (a == int'(x_of(i))) e = ptr_of(i);
      if (a == int'(tgt_of(i))) e = '0;
    end
    return e;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_reset_state();
    chk("R1", "pc", 32'(dbg_pc), 0);
    chk("R1", "mar", 32'(dbg_mar), 0);
    chk("R1", "mbr", 32'(dbg_mbr), 0);
    chk("R1", "ir", 32'(dbg_ir), 0);
    chk("R1", "ac", 32'(dbg_ac), 0);
    chk("R1", "step", 32'(dbg_step), 1);
    chk("R1", "phase", 32'(dbg_phase), 0);
    chk("R1", "we", 32'(mem_we), 0);
  endtask

  // One store-indirect instruction, sampled at each negedge; k = edges since its fetch began
  task automatic run_instr(input int i);
    for (int k = 0; k < 9; k++) begin
      case (k)
        0: begin
          chk("R2", "fetch t0 step", 32'(dbg_step), 1);
          chk("R9", "bus=pc", 32'(dbg_bus), 32'(i));
          chk("R7", "ctl idle", 32'(dbg_ctl), 0);
        end
        1: begin
          chk("R3", "mar=pc", 32'(dbg_mar), 32'(i));
          chk("R9", "bus=mem", 32'(dbg_bus), 32'(instr_of(i)));
        end
        2: begin
          chk("R3", "ir", 32'(dbg_ir), 32'(instr_of(i)));
          chk("R3", "pc+1", 32'(dbg_pc), 32'(i + 1));
          chk("R4", "decode phase", 32'(dbg_phase), 1);
        end
        3: begin
          chk("R4", "exec phase", 32'(dbg_phase), 2);
          chk("R7", "T0 lines", 32'(dbg_ctl), 32'h0F);
          chk("R9", "bus=ir", 32'(dbg_bus), 32'(instr_of(i)));
        end
        4: begin
          chk("R5", "mar=x", 32'(dbg_mar), 32'(x_of(i)));
          chk("R7", "T1 lines", 32'(dbg_ctl), 32'h18);
          chk("R2", "T1 step", 32'(dbg_step), 2);
        end
        5: begin
          chk("R5", "mbr=ptr", 32'(dbg_mbr), 32'(ptr_of(i)));
          chk("R7", "T2 lines", 32'(dbg_ctl), 32'h0B);
        end
        6: begin
          chk("R6", "mar=ptr low", 32'(dbg_mar), 32'(tgt_of(i)));
          chk("R7", "T3 lines", 32'(dbg_ctl), 32'h1C);
          chk("R9", "bus=ac", 32'(dbg_bus), 0);
        end
        7: begin
          chk("R5", "mbr=ac", 32'(dbg_mbr), 0);
          chk("R7", "T4 lines", 32'(dbg_ctl), 32'h03);
          chk("R8", "we at T4", 32'(mem_we), 1);
          chk("R8", "wr addr", 32'(mem_addr), 32'(tgt_of(i)));
        end
        default: begin
          chk("R10", "T5 step", 32'(dbg_step), 32'h20);
          chk("R7", "T5 lines", 32'(dbg_ctl), 0);
          chk("R8", "we off", 32'(mem_we), 0);
          chk("R5", "target written", 32'(mem[tgt_of(i)]), 0);
        end
      endcase
      if (k != 7) chk("R8", "no write", 32'(mem_we), 0);
      @(negedge clk);
    end
    chk("R10", "back to fetch", 32'(dbg_phase), 0);
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) mem[a] = fill_word(a);
    for (int i = 0; i < NI; i++) begin
      mem[i]       = instr_of(i);
      mem[x_of(i)] = ptr_of(i);
    end
    mem[NI] = 16'h7000;

    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    #1;
    for (int i = 0; i < NI; i++) run_instr(i);

    // Unsupported opcode: fetch and decode, then halt
    @(negedge clk);
    @(negedge clk);
    chk("R4", "bad ir", 32'(dbg_ir), 32'h7000);
    @(negedge clk);
    chk("R4", "halt phase", 32'(dbg_phase), 3);
    chk("R4", "halted", 32'(halted), 1);
    repeat (20) @(negedge clk);
    chk("R4", "still halted", 32'(halted), 1);
    chk("R4", "pc frozen", 32'(dbg_pc), 32'(NI + 1));
    chk("R2", "halt step", 32'(dbg_step), 1);

    // Whole-memory sweep
    begin
      int bad = 0;
      for (int a = 0; a < DEPTH; a++) if (mem[a] !== expect_word(a)) bad++;
      chk("R5", "memory mismatches", 32'(bad), 0);
    end

    // Reset while halted, then reset during execution
    rst = 1'b1;
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5", "mid exec phase", 32'(dbg_phase), 2);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule